// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block is the front end of an eight-line interrupt controller. It samples the request lines once per clock and keeps one pending-request bit per line. Each line works either edge-sensitive or level-sensitive, as its bit in a byte-wide trigger-mode register selects. An edge-sensitive line latches a request when it goes from low to high. The request then stays pending until an acknowledge clears it. A level-sensitive line has a pending bit that simply follows the input.

A build-time writable-bit mask limits the trigger-mode register. A line whose mask bit is 0 always reads back 0 and stays edge-sensitive whatever is written. For every new assertion of a line, the block reports one of three outcomes: the line is masked by the external mask input, the request joins one already pending, or it is a fresh request. An initialization strobe forgets the stored previous levels of all lines, so that edge detection starts again.

Top module: `irq_req_latch`

## Requirements
- R1: A line whose trigger-mode bit is 1 has its pending bit equal to the input level sampled at the previous clock edge. The bit is set when the line was high and cleared when it was low.
- R2: A line whose trigger-mode bit is 0 sets its pending bit only when it is sampled high while its stored previous level is low. Holding the line high sets nothing further.
- R3: On an edge-sensitive line, a low input clears only the stored previous level. The pending bit stays set.
- R4: A new assertion is a line sampled high with a stored previous level of 0. For each new assertion, exactly one status bit pulses in the following cycle. `stMasked` pulses when the line's `maskIn` bit is 1. Otherwise `stCoalesced` pulses if the pending bit was already set, and `stNew` pulses if it was not. With no new assertion, all three status bits stay 0. The mask does not stop the pending bit from being latched.
- R5: A trigger-mode write stores the written byte ANDed with the parameter `WRITABLE_MASK` (default 8'hF8), and `trigRdData` returns the stored value from the next cycle on. Lines whose mask bit is 0 therefore stay edge-sensitive.
- R6: An `ackClr` bit clears the pending bit of its line only if that line is edge-sensitive. On a level-sensitive line it has no effect.
- R7: When an acknowledge and a new edge arrive on the same edge-sensitive line in the same cycle, the line stays pending.
- R8: In the cycle `initCmd` is high, all stored previous levels clear, no edge is latched and no status bit pulses. A line that is still high at the next sample is then taken as a new assertion.
- R9: After reset, the pending bits, the stored previous levels, the trigger-mode register and all status outputs are 0.
- R10: All eight lines are processed independently and in parallel in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | 8 | Request line levels, sampled each clock |
| maskIn | input | 8 | External per-line mask, used only for status classification |
| trigWrEn | input | 1 | Trigger-mode register write strobe |
| trigWrData | input | 8 | Trigger-mode write byte (1 = level-sensitive) |
| trigRdData | output | 8 | Trigger-mode register contents |
| ackClr | input | 8 | Per-line acknowledge clear |
| initCmd | input | 1 | Initialization strobe, forgets the stored previous levels |
| irrOut | output | 8 | Pending-request bits |
| stNew | output | 8 | Fresh request latched, one-cycle pulse |
| stCoalesced | output | 8 | Request joined an already pending one, one-cycle pulse |
| stMasked | output | 8 | New assertion on a masked line, one-cycle pulse |

## Verification
The assertions assume that every input is a clean synchronous level that is valid at each clock edge. Acknowledge and initialization are taken as single-cycle strobes that may coincide with line changes. The stimulus changes all inputs one time unit after a rising edge and holds them for a full cycle. It raises acknowledge and init strobes for one cycle only, except where a test holds an acknowledge deliberately against a level-sensitive line. It never leaves the external mask in an unknown state.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int unsigned NUM_LINES = 8;

  typedef logic [NUM_LINES-1:0] lineVec_t;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic     initSweep;  // forget stored previous levels
    lineVec_t ackClear;   // per-line acknowledge
    lineVec_t levelSel;   // 1 = level-sensitive
  } latchCtrl_t;
endpackage

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
#(
  parameter lineVec_t WRITABLE_MASK = 8'hF8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigWrEn,
  input  lineVec_t   trigWrData,
  input  lineVec_t   ackClr,
  input  logic       initCmd,
  output lineVec_t   trigRdData,
  output latchCtrl_t ctrlOut
);
  lineVec_t trigReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigReg <= '0;
    end else if (trigWrEn) begin
      trigReg <= trigWrData & WRITABLE_MASK;
    end
  end

  assign trigRdData        = trigReg;
  assign ctrlOut.levelSel  = trigReg;
  assign ctrlOut.ackClear  = ackClr;
  assign ctrlOut.initSweep = initCmd;

  AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !trigWrEn |=> $stable(trigReg)); // R5
endmodule

// File: rtl/irq_latch_path.sv
module irq_latch_path
  import irq_latch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  lineVec_t   lineIn,
  input  lineVec_t   maskIn,
  input  latchCtrl_t ctrlIn,
  output lineVec_t   irrOut,
  output lineVec_t   stNew,
  output lineVec_t   stCoalesced,
  output lineVec_t   stMasked
);
  lineVec_t lastLevel;
  lineVec_t irrReg;
  lineVec_t newAssert;
  lineVec_t irrNext;

  assign newAssert = lineIn & ~lastLevel & {NUM_LINES{~ctrlIn.initSweep}};

  for (genvar i = 0; i < NUM_LINES; i++) begin : gLine
    always_comb begin
      if (ctrlIn.levelSel[i]) begin
        irrNext[i] = lineIn[i];
      end else begin
        irrNext[i] = (irrReg[i] & ~ctrlIn.ackClear[i]) | newAssert[i];
      end
    end

    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rstN)
      $past(ctrlIn.levelSel[i]) |-> (irrOut[i] == $past(lineIn[i]))); // R1
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      ($past(!ctrlIn.levelSel[i] && irrOut[i] && !ctrlIn.ackClear[i])) |-> irrOut[i]); // R3
    AST_ACK_EDGE: assert property (@(posedge clk) disable iff (!rstN)
      ($past(!ctrlIn.levelSel[i] && ctrlIn.ackClear[i] && !lineIn[i])) |-> !irrOut[i]); // R6
    AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({stNew[i], stCoalesced[i], stMasked[i]})); // R4
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastLevel   <= '0;
      irrReg      <= '0;
      stNew       <= '0;
      stCoalesced <= '0;
      stMasked    <= '0;
    end else begin
      lastLevel   <= ctrlIn.initSweep ? '0 : lineIn;
      irrReg      <= irrNext;
      stNew       <= newAssert & ~maskIn & ~irrReg;
      stCoalesced <= newAssert & ~maskIn & irrReg;
      stMasked    <= newAssert & maskIn;
    end
  end

  assign irrOut = irrReg;

  AST_INIT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ctrlIn.initSweep |=> (stNew == '0 && stCoalesced == '0 && stMasked == '0)); // R8
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_latch_pkg::*;
#(
  parameter lineVec_t WRITABLE_MASK = 8'hF8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] lineIn,
  input  logic [7:0] maskIn,
  input  logic       trigWrEn,
  input  logic [7:0] trigWrData,
  output logic [7:0] trigRdData,
  input  logic [7:0] ackClr,
  input  logic       initCmd,
  output logic [7:0] irrOut,
  output logic [7:0] stNew,
  output logic [7:0] stCoalesced,
  output logic [7:0] stMasked
);
  latchCtrl_t ctrlBus;

  irq_latch_ctrl #(.WRITABLE_MASK(WRITABLE_MASK)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .trigWrEn   (trigWrEn),
    .trigWrData (trigWrData),
    .ackClr     (ackClr),
    .initCmd    (initCmd),
    .trigRdData (trigRdData),
    .ctrlOut    (ctrlBus)
  );

  irq_latch_path uPath (
    .clk         (clk),
    .rstN        (rstN),
    .lineIn      (lineIn),
    .maskIn      (maskIn),
    .ctrlIn      (ctrlBus),
    .irrOut      (irrOut),
    .stNew       (stNew),
    .stCoalesced (stCoalesced),
    .stMasked    (stMasked)
  );
endmodule

// File: tb/tb_irq_req_latch.sv
module tb_irq_req_latch;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] lineIn = '0;
  logic [7:0] maskIn = '0;
  logic       trigWrEn = 1'b0;
  logic [7:0] trigWrData = '0;
  logic [7:0] trigRdData;
  logic [7:0] ackClr = '0;
  logic       initCmd = 1'b0;
  logic [7:0] irrOut, stNew, stCoalesced, stMasked;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_req_latch dut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .maskIn(maskIn),
    .trigWrEn(trigWrEn), .trigWrData(trigWrData), .trigRdData(trigRdData),
    .ackClr(ackClr), .initCmd(initCmd), .irrOut(irrOut),
    .stNew(stNew), .stCoalesced(stCoalesced), .stMasked(stMasked)
  );

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    rstN = 1'b0; lineIn = '0; maskIn = '0; ackClr = '0; initCmd = 1'b0; trigWrEn = 1'b0;
    repeat (3) step();
    rstN = 1'b1;
  endtask

  task automatic writeTrig(input logic [7:0] val);
    trigWrEn = 1'b1; trigWrData = val;
    step();
    trigWrEn = 1'b0;
  endtask

  task automatic testReset();
    chk("R9", "irr", irrOut, 8'h00);
    chk("R9", "trig", trigRdData, 8'h00);
    chk("R9", "status", stNew | stCoalesced | stMasked, 8'h00);
  endtask

  task automatic testEdge();
    lineIn = 8'h08; step();
    chk("R2", "irr rise", irrOut, 8'h08);
    chk("R4", "new", stNew, 8'h08);
    step();
    chk("R2", "irr hold", irrOut, 8'h08);
    chk("R2", "no status while held", stNew | stCoalesced, 8'h00);
    lineIn = 8'h00; step();
    chk("R3", "irr after low", irrOut, 8'h08);
    lineIn = 8'h08; step();
    chk("R4", "coalesced", stCoalesced, 8'h08);
    chk("R4", "not new", stNew, 8'h00);
    lineIn = 8'h00; ackClr = 8'h08; step(); ackClr = 8'h00;
    chk("R6", "edge ack clears", irrOut, 8'h00);
  endtask

  task automatic testTrigWrite();
    writeTrig(8'h27);
    chk("R5", "write 27", trigRdData, 8'h20);
    writeTrig(8'hFF);
    chk("R5", "write FF", trigRdData, 8'hF8);
  endtask

  task automatic testLevel();
    lineIn = 8'h10; step();
    chk("R1", "level high", irrOut, 8'h10);
    chk("R4", "level new", stNew, 8'h10);
    lineIn = 8'h00; step();
    chk("R1", "level low clears", irrOut, 8'h00);
    lineIn = 8'h10; step();
    ackClr = 8'h10; step();
    chk("R6", "level ack ignored", irrOut, 8'h10);
    step(); ackClr = 8'h00;
    chk("R6", "level ack held ignored", irrOut, 8'h10);
    lineIn = 8'h00; step();
    chk("R1", "level drop", irrOut, 8'h00);
  endtask

  task automatic testEdgeOnly();
    lineIn = 8'h02; step();
    lineIn = 8'h00; step();
    chk("R5", "line1 stays edge", irrOut, 8'h02);
    ackClr = 8'h02; step(); ackClr = 8'h00;
    chk("R6", "line1 ack", irrOut, 8'h00);
  endtask

  task automatic testMask();
    maskIn = 8'h20; lineIn = 8'h20; step();
    chk("R4", "masked", stMasked, 8'h20);
    chk("R4", "masked not new", stNew | stCoalesced, 8'h00);
    chk("R4", "masked still latched", irrOut, 8'h20);
    maskIn = 8'h00; lineIn = 8'h00; step();
    chk("R1", "line5 drop", irrOut, 8'h00);
  endtask

  task automatic testAckRise();
    lineIn = 8'h04; step();
    lineIn = 8'h00; step();
    lineIn = 8'h04; ackClr = 8'h04; step(); ackClr = 8'h00;
    chk("R7", "ack with edge keeps pending", irrOut, 8'h04);
    chk("R4", "coalesced on ack cycle", stCoalesced, 8'h04);
    lineIn = 8'h00; ackClr = 8'h04; step(); ackClr = 8'h00;
    chk("R6", "line2 cleared", irrOut, 8'h00);
  endtask

  task automatic testInit();
    lineIn = 8'h01; step();
    ackClr = 8'h01; step(); ackClr = 8'h00;
    chk("R6", "ack while high", irrOut, 8'h00);
    initCmd = 1'b1; step(); initCmd = 1'b0;
    chk("R8", "no latch in init cycle", irrOut, 8'h00);
    chk("R8", "no status in init cycle", stNew, 8'h00);
    step();
    chk("R8", "relatch after init", irrOut, 8'h01);
    chk("R8", "new after init", stNew, 8'h01);
    lineIn = 8'h00; ackClr = 8'h01; step(); ackClr = 8'h00;
  endtask

  task automatic testParallel();
    lineIn = 8'h68; step();
    chk("R10", "parallel irr", irrOut, 8'h68);
    chk("R10", "parallel new", stNew, 8'h68);
    maskIn = 8'h40; lineIn = 8'h00; step();
    lineIn = 8'h68; step();
    chk("R10", "parallel coalesced", stCoalesced, 8'h28);
    chk("R10", "parallel masked", stMasked, 8'h40);
    maskIn = 8'h00; lineIn = 8'h00;
  endtask

  initial begin
    doReset();
    step();
    testReset();
    testEdge();
    testTrigWrite();
    testLevel();
    testEdgeOnly();
    testMask();
    testAckRise();
    testInit();
    doReset();
    testParallel();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule